// File: doc/BRIEF.md
# Priority-Leveled DRAM Refresh Scheduler

This block decides when a DDR2 memory controller inserts auto-refresh commands. Rather than firing refreshes on a fixed period, it keeps a single credit counter that falls by one every enabled clock. Each completed refresh adds the programmed average interval to the counter. Two programmable thresholds compare against this credit and sort the refresh need into three urgency grades. When credit is low, a refresh takes the next free command slot. When credit is moderate, a refresh waits for a cycle with no request pending. When credit is high, no refresh is started.

When a refresh is granted, the scheduler first looks at the controller's open-bank flags. If any bank is open, it requests a precharge-all command before the refresh. It holds each command request until the command sequencer acknowledges it, and it stalls new data commands until the refresh itself is acknowledged. One cycle after the refresh acknowledge, it pulses a clear so the controller marks every bank closed.

Top module: `refresh_sched`

## Requirements
- R1: With `en` low, no new refresh sequence starts and the credit counter keeps its value; with `en` high, the counter moves every cycle.
- R2: The credit counter is 14 bits wide, resets to 0, and drops by exactly one per cycle while `en` is high.
- R3: On the cycle a refresh command (`cmd_is_ref`=1) is acknowledged, `interval` is added to the counter in the same cycle as the decrement, so the result is count + interval - 1.
- R4: The counter saturates at 16383 and at 0 instead of wrapping.
- R5: Urgent grade (count <= `th_lo`): a sequence starts in any cycle with `slot_idle`=1, whatever `req_pending` is.
- R6: Idle-only grade (`th_lo` < count <= `th_hi`): a sequence starts only when `slot_idle`=1 and `req_pending`=0.
- R7: Hold grade (count > `th_hi`): no sequence starts.
- R8: If any `bank_open` bit is 1 when a sequence starts, the first request is precharge-all (`cmd_is_ref`=0). After its acknowledge, the refresh request (`cmd_is_ref`=1) follows in the next cycle. With all banks closed, the refresh is requested directly.
- R9: `cmd_req` and `cmd_is_ref` stay unchanged until `cmd_ack`. `hold_data` is high whenever a command is requested.
- R10: `banks_clear` is high for exactly one cycle, in the cycle after the refresh acknowledge, and `cmd_req` is then low.
- R11: Dropping `en` while a request is outstanding and not acknowledged cancels it in the next cycle. No credit is added and no clear pulse is given.
- R12: After reset, `cmd_req`, `cmd_is_ref`, `hold_data` and `banks_clear` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Refresh enable |
| interval | input | 14 | Credit added per refresh |
| th_lo | input | 14 | Upper bound of the urgent grade |
| th_hi | input | 14 | Upper bound of the idle-only grade |
| req_pending | input | 1 | Request queue holds a request |
| slot_idle | input | 1 | Command slot free this cycle |
| bank_open | input | 8 | Per-bank open-row flags |
| cmd_ack | input | 1 | Sequencer accepted the requested command |
| cmd_req | output | 1 | Refresh-path command request |
| cmd_is_ref | output | 1 | 1 = refresh, 0 = precharge-all |
| hold_data | output | 1 | Stall new data commands |
| banks_clear | output | 1 | One-cycle pulse: mark all banks closed |

## Verification
The counter is internal, so the hardest conditions to reach are the exact threshold boundaries and saturation at the top of the counter. To reach them, the bench first runs one refresh from a zero count. This loads a known credit of interval - 1. It then watches the cycle in which the grade changes. For saturation, two back-to-back refreshes are run with a full-scale interval. The next grade then shows whether the sum was clamped or wrapped.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic [1:0] {
        LVL_URGENT    = 2'd0,
        LVL_IDLE_ONLY = 2'd1,
        LVL_HOLD      = 2'd2
    } urg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PALL = 2'd1,
        ST_REF  = 2'd2
    } seq_t;
endpackage

// File: rtl/refsched_credit.sv
module refsched_credit #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             add,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cr_t;

    cr_t cr_q, cr_d;
    logic [CNT_W:0] sum_w, dif_w;

    always_comb begin
        cr_d  = cr_q;
        sum_w = {1'b0, cr_q.cnt} + (add ? {1'b0, interval} : '0);
        dif_w = (en && sum_w != '0) ? sum_w - (CNT_W+1)'(1) : sum_w;
        cr_d.cnt = dif_w[CNT_W] ? CNT_MAX : dif_w[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign cnt = cr_q.cnt;

    // R1
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !add) |=> $stable(cnt));
    // R2
    dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !add && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
    // R4
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !add && cnt == '0) |=> (cnt == '0));
    // R3
    credit_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add && interval != '0) |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/refsched_grade.sv
module refsched_grade
    import refsched_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] th_lo,
    input  logic [CNT_W-1:0] th_hi,
    output urg_t             urg
);
    always_comb begin
        if (cnt <= th_lo)      urg = LVL_URGENT;
        else if (cnt <= th_hi) urg = LVL_IDLE_ONLY;
        else                   urg = LVL_HOLD;
    end
endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
    import refsched_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  urg_t                 urg,
    input  logic                 req_pending,
    input  logic                 slot_idle,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 cmd_ack,
    output logic                 cmd_req,
    output logic                 cmd_is_ref,
    output logic                 hold_data,
    output logic                 banks_clear,
    output logic                 ref_done
);
    typedef struct packed {
        seq_t st;
        logic clr;
    } sq_t;

    sq_t sq_q, sq_d;
    logic start_w;

    always_comb begin
        sq_d     = sq_q;
        ref_done = 1'b0;
        start_w  = en && slot_idle &&
                   ((urg == LVL_URGENT) || (urg == LVL_IDLE_ONLY && !req_pending));
        case (sq_q.st)
            ST_IDLE: begin
                if (start_w) sq_d.st = (|bank_open) ? ST_PALL : ST_REF;
            end
            ST_PALL: begin
                if (cmd_ack)  sq_d.st = ST_REF;
                else if (!en) sq_d.st = ST_IDLE;
            end
            ST_REF: begin
                if (cmd_ack) begin
                    sq_d.st  = ST_IDLE;
                    ref_done = 1'b1;
                end else if (!en) begin
                    sq_d.st = ST_IDLE;
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
        sq_d.clr = ref_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{st: ST_IDLE, clr: 1'b0};
        else        sq_q <= sq_d;
    end

    assign cmd_req     = (sq_q.st != ST_IDLE);
    assign cmd_is_ref  = (sq_q.st == ST_REF);
    assign hold_data   = cmd_req;
    assign banks_clear = sq_q.clr;

    // R9
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack && en) |=> (cmd_req && $stable(cmd_is_ref)));
    // R8
    pall_then_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_is_ref && cmd_ack) |=> (cmd_req && cmd_is_ref));
    // R10
    clear_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_is_ref && cmd_ack) |=> (banks_clear && !cmd_req));
    // R10
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        banks_clear |=> !banks_clear);
    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cmd_ack) |=> !cmd_req);
    // R7
    hold_grade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urg == LVL_HOLD && !cmd_req) |=> !cmd_req);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [CNT_W-1:0]     interval,
    input  logic [CNT_W-1:0]     th_lo,
    input  logic [CNT_W-1:0]     th_hi,
    input  logic                 req_pending,
    input  logic                 slot_idle,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 cmd_ack,
    output logic                 cmd_req,
    output logic                 cmd_is_ref,
    output logic                 hold_data,
    output logic                 banks_clear
);
    logic [CNT_W-1:0] cnt_w;
    urg_t             urg_w;
    logic             ref_done_w;

    refsched_credit #(.CNT_W(CNT_W)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .add      (ref_done_w),
        .interval (interval),
        .cnt      (cnt_w)
    );

    refsched_grade #(.CNT_W(CNT_W)) u_grade (
        .cnt   (cnt_w),
        .th_lo (th_lo),
        .th_hi (th_hi),
        .urg   (urg_w)
    );

    refsched_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .urg         (urg_w),
        .req_pending (req_pending),
        .slot_idle   (slot_idle),
        .bank_open   (bank_open),
        .cmd_ack     (cmd_ack),
        .cmd_req     (cmd_req),
        .cmd_is_ref  (cmd_is_ref),
        .hold_data   (hold_data),
        .banks_clear (banks_clear),
        .ref_done    (ref_done_w)
    );

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!cmd_req && !banks_clear));
endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [13:0] interval, th_lo, th_hi;
    logic        req_pending, slot_idle, cmd_ack;
    logic [7:0]  bank_open;
    logic        cmd_req, cmd_is_ref, hold_data, banks_clear;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    refresh_sched u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .interval(interval),
        .th_lo(th_lo), .th_hi(th_hi), .req_pending(req_pending),
        .slot_idle(slot_idle), .bank_open(bank_open), .cmd_ack(cmd_ack),
        .cmd_req(cmd_req), .cmd_is_ref(cmd_is_ref),
        .hold_data(hold_data), .banks_clear(banks_clear)
    );

    typedef struct packed {
        logic [13:0] ivl;
        logic        pend;
        logic        idle;
        logic [7:0]  banks;
        logic        exp_req;
        logic        exp_ref;
    } vec_t;

    // thresholds 100 / 200; credit after first refresh = ivl - 1
    localparam vec_t VECS [12] = '{
        '{14'd50,  1'b1, 1'b1, 8'h00, 1'b1, 1'b1},  // R5 urgent, pending ignored
        '{14'd50,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 no free slot
        '{14'd150, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},  // R6 pending blocks
        '{14'd150, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},  // R6 queue empty
        '{14'd150, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R6 no free slot
        '{14'd300, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // R7 hold
        '{14'd101, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},  // R5 count == th_lo, R3 credit
        '{14'd102, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0},  // R6 count == th_lo+1
        '{14'd201, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},  // R6 count == th_hi
        '{14'd202, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // R7 count == th_hi+1
        '{14'd50,  1'b0, 1'b1, 8'h04, 1'b1, 1'b0},  // R8 one bank open
        '{14'd150, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0}   // R8 all banks open
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; cmd_ack = 1'b0;
        req_pending = 1'b0; slot_idle = 1'b0; bank_open = 8'h00;
        interval = 14'd0; th_lo = 14'd100; th_hi = 14'd200;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // wait for a refresh request, acknowledge it; returns at negedge after the ack edge
    task automatic take_ref(input string tag);
        int n = 0;
        while (!(cmd_req && cmd_is_ref) && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(cmd_req && cmd_is_ref), 1);
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; cmd_ack = 1'b0;
        req_pending = 1'b0; slot_idle = 1'b0; bank_open = 8'h00;
        interval = '0; th_lo = '0; th_hi = '0;

        // R12 reset state
        do_reset();
        chk("R12 cmd_req", int'(cmd_req), 0);
        chk("R12 hold_data", int'(hold_data), 0);
        chk("R12 banks_clear", int'(banks_clear), 0);

        // table walk
        foreach (VECS[i]) begin
            do_reset();
            interval = VECS[i].ivl;
            slot_idle = 1'b1;
            en = 1'b1;
            take_ref($sformatf("row %0d first refresh", i));
            req_pending = VECS[i].pend;
            slot_idle   = VECS[i].idle;
            bank_open   = VECS[i].banks;
            @(negedge clk);
            chk($sformatf("R5-7 grade row %0d req", i), int'(cmd_req), int'(VECS[i].exp_req));
            if (VECS[i].exp_req)
                chk($sformatf("R8 row %0d kind", i), int'(cmd_is_ref), int'(VECS[i].exp_ref));
        end

        // R1: disabled, urgent credit, free slots -> nothing
        do_reset();
        slot_idle = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 disabled no request", int'(cmd_req), 0);

        // R8 R9 R10: precharge-all sequence
        do_reset();
        interval = 14'd50;
        bank_open = 8'h81; slot_idle = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R8 pall req", int'(cmd_req), 1);
        chk("R8 pall kind", int'(cmd_is_ref), 0);
        chk("R9 hold_data", int'(hold_data), 1);
        repeat (3) @(negedge clk);
        chk("R9 req held", int'(cmd_req), 1);
        chk("R9 kind held", int'(cmd_is_ref), 0);
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        slot_idle = 1'b0;
        chk("R8 ref after pall", int'(cmd_is_ref), 1);
        chk("R9 hold during ref", int'(hold_data), 1);
        chk("R10 no early clear", int'(banks_clear), 0);
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        chk("R10 clear pulse", int'(banks_clear), 1);
        chk("R10 req dropped", int'(cmd_req), 0);
        chk("R9 hold released", int'(hold_data), 0);
        @(negedge clk);
        chk("R10 clear one cycle", int'(banks_clear), 0);

        // R11: abort before ack
        do_reset();
        interval = 14'd50;
        slot_idle = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R11 req raised", int'(cmd_req), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R11 req cancelled", int'(cmd_req), 0);
        chk("R11 no clear", int'(banks_clear), 0);
        repeat (5) @(negedge clk);
        chk("R11 stays off", int'(cmd_req), 0);
        req_pending = 1'b1; en = 1'b1;
        @(negedge clk);
        chk("R11 no credit given", int'(cmd_req), 1);

        // R2: decrement rate, credit 149 reaches th_lo=100 after 50 edges
        do_reset();
        interval = 14'd150;
        slot_idle = 1'b1; en = 1'b1;
        take_ref("R2 first refresh");
        req_pending = 1'b1;
        for (int k = 1; k <= 49; k++) @(negedge clk);
        chk("R2 before boundary", int'(cmd_req), 0);
        @(negedge clk);
        chk("R2 at boundary", int'(cmd_req), 1);

        // R4: saturation at the top
        do_reset();
        interval = 14'd16383; th_lo = 14'd16382; th_hi = 14'd16383;
        slot_idle = 1'b1; en = 1'b1;
        take_ref("R4 first refresh");
        take_ref("R4 second refresh");
        req_pending = 1'b1;
        @(negedge clk);
        chk("R4 saturated grade", int'(cmd_req), 0);
        @(negedge clk);
        chk("R4 one below max", int'(cmd_req), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule